// File: doc/BRIEF.md
# Gray-Coded Channel Readout Sequencer

This block generates the channel number that steers a 128-way readout multiplexer after a line of detector charge has been captured. The channels are split into a lower bank (0 to 63) and an upper bank (64 to 127). Each bank has its own step counter, and that counter moves only in cycles where the bank's enable input is high. The first three steps of each bank are dummy slots that select no channel. They are followed by the bank's 64 channels, one clock cycle each, so a full enable window of 67 clocks visits every channel in the bank once. The counter state is held in reflected Gray code. An active-low line-clear input rewinds both bank counters at the start of every line.

For debug, a host can freeze the output on a single channel. With the test enable held high, the host writes the word 0x01, then 0x02, then a Gray-coded slot word. From the next cycle the block holds that channel. The bank counters stop and the gated enables go low until the test enable is dropped.

Top module: `gray_readout_seq`

## Requirements
- R1: With `rst` high at a clock edge, both bank counters return to slot 0 and the unlock sequence returns to waiting for its first word.
- R2: While only `bank_en_lo` is high, the first three cycles show `chan_valid` low with `chan` 0. The next 64 cycles show channels 0 to 63 in ascending order, one per cycle, with `chan_valid` high. The counter state changes in exactly one bit per step (reflected Gray code).
- R3: While only `bank_en_hi` is high, the upper bank follows the same three dummy slots and then shows channels 64 to 127 in ascending order.
- R4: A bank whose enable is low keeps its position. When the enable returns, the bank continues with the next slot.
- R5: After 67 enabled slots a bank stops counting. Further enabled cycles show `chan_valid` low, and the bank does not wrap until it is cleared.
- R6: `line_clr_n` low at a clock edge returns both bank counters to slot 0 and overrides an enable in the same cycle. The outputs in that cycle still show the slot that was current before the clear.
- R7: When both bank enables are high, the outputs show the lower bank and both bank counters advance.
- R8: With `test_en` high, the writes 0x01, 0x02 and then any word W (strobed by `test_wr`) put the block into hold from the next cycle. In hold, `gate_lo` and `gate_hi` are low, the counters do not advance, and further writes replace W. Writes made while `test_en` is low have no effect.
- R9: Any written word other than the one the unlock sequence expects next sends the sequence back to waiting for 0x01.
- R10: In hold, W is decoded as a reflected Gray code into slot s. Slots 0, 1 and 2 (W = 0x00, 0x01, 0x03) show `chan_valid` low and `chan` 0. Slot s of 3 or more shows channel s−3 with `chan_valid` high. For example, W = 0x02 gives channel 0 and W = 0x62 gives channel 64.
- R11: Dropping `test_en` ends hold at the next clock edge, and the banks resume from the positions they had when hold began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clr_n | input | 1 | Active-low per-line clear of both bank counters |
| bank_en_lo | input | 1 | Step enable for channels 0 to 63 |
| bank_en_hi | input | 1 | Step enable for channels 64 to 127 |
| test_en | input | 1 | Test mode enable |
| test_word | input | 7 | Word written during unlock and hold |
| test_wr | input | 1 | Write strobe for `test_word` |
| chan | output | 7 | Selected channel number (0 when not valid) |
| chan_valid | output | 1 | A real channel is selected |
| gate_lo | output | 1 | Lower-bank enable after the hold gate |
| gate_hi | output | 1 | Upper-bank enable after the hold gate |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a line clear arriving while a bank enable is high. The bench provokes it by pulling `line_clr_n` low in a cycle where the lower bank is mid-sweep, then checks that the next cycles restart from the three dummy slots. The second pair is hold starting while a bank enable stays high. The bench leaves `bank_en_lo` asserted across the unlock and into hold, checks that the gated enables drop and the held channel is shown, and checks that after release the bank resumes from its frozen slot. A reference model in the bench tracks both banks and the unlock state and predicts every cycle.

// File: rtl/gray_seq_pkg.sv
package gray_seq_pkg;

    parameter int BANK_CH     = 64;
    parameter int DUMMY_SLOTS = 3;

    localparam int NUM_BANKS = 2;
    localparam int SLOTS     = DUMMY_SLOTS + BANK_CH;
    localparam int CNT_W     = $clog2(SLOTS + 1);
    localparam int BANK_W    = $clog2(BANK_CH);
    localparam int CH_W      = $clog2(NUM_BANKS * BANK_CH);

    typedef logic [CNT_W-1:0] gcode_t;
    typedef logic [CH_W-1:0]  chan_t;

    localparam gcode_t SLOT_END   = gcode_t'(SLOTS);
    localparam gcode_t SLOT_FIRST = gcode_t'(DUMMY_SLOTS);
    localparam chan_t  TSLOT_FIRST = chan_t'(DUMMY_SLOTS);
    localparam chan_t  KEY_ONE    = chan_t'(1);
    localparam chan_t  KEY_TWO    = chan_t'(2);

    typedef enum logic [1:0] {
        UNLK_IDLE,
        UNLK_GOT1,
        UNLK_GOT2,
        UNLK_HOLD
    } unlk_state_t;

    typedef struct packed {
        logic  valid;
        chan_t num;
    } chan_sel_t;

    function automatic gcode_t cnt_gray_dec(input gcode_t g);
        gcode_t b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic chan_t ch_gray_dec(input chan_t g);
        chan_t b;
        b[CH_W-1] = g[CH_W-1];
        for (int i = CH_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic gcode_t cnt_gray_enc(input gcode_t b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/seq_bank_counter.sv
module seq_bank_counter
    import gray_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   line_clr_n,
    input  logic   step_en,
    input  logic   hold,
    output gcode_t slot
);

    gcode_t gray_q;
    logic   adv;

    assign slot = cnt_gray_dec(gray_q);
    assign adv  = step_en && (slot < SLOT_END);

    always_ff @(posedge clk) begin
        if (rst || !line_clr_n) begin
            gray_q <= '0;
        end else if (adv) begin
            gray_q <= cnt_gray_enc(slot + gcode_t'(1));
        end
    end

    // R2: each advance flips exactly one stored bit
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && line_clr_n) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

    // R5: the slot never passes the end of the window
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        slot <= SLOT_END);

    // R6: a line clear rewinds the counter
    assert_line_clear_R6: assert property (@(posedge clk) disable iff (rst)
        !line_clr_n |=> (gray_q == '0));

    // R8: no movement while the test hold is active
    assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (hold && line_clr_n) |=> $stable(gray_q));

endmodule

// File: rtl/seq_test_unlock.sv
module seq_test_unlock
    import gray_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  test_en,
    input  logic  test_wr,
    input  chan_t test_word,
    output logic  hold,
    output chan_t held_word
);

    unlk_state_t state;

    always_ff @(posedge clk) begin
        if (rst || !test_en) begin
            state <= UNLK_IDLE;
            if (rst) held_word <= '0;
        end else if (test_wr) begin
            unique case (state)
                UNLK_IDLE: state <= (test_word == KEY_ONE) ? UNLK_GOT1 : UNLK_IDLE;
                UNLK_GOT1: state <= (test_word == KEY_TWO) ? UNLK_GOT2 : UNLK_IDLE;
                UNLK_GOT2, UNLK_HOLD: begin
                    state     <= UNLK_HOLD;
                    held_word <= test_word;
                end
                default: state <= UNLK_IDLE;
            endcase
        end
    end

    assign hold = (state == UNLK_HOLD);

    // R9: reaching the second stage needs the first key word just written
    assert_key_order_R9: assert property (@(posedge clk) disable iff (rst)
        ((state == UNLK_GOT1) && ($past(state) != UNLK_GOT1)) |->
            ($past(test_word) == KEY_ONE && $past(test_wr)));

endmodule

// File: rtl/gray_readout_seq.sv
module gray_readout_seq
    import gray_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_clr_n,
    input  logic       bank_en_lo,
    input  logic       bank_en_hi,
    input  logic       test_en,
    input  logic [6:0] test_word,
    input  logic       test_wr,
    output logic [6:0] chan,
    output logic       chan_valid,
    output logic       gate_lo,
    output logic       gate_hi
);

    logic                 hold;
    chan_t                held_word;
    logic [NUM_BANKS-1:0] bank_en;
    logic [NUM_BANKS-1:0] gate;
    gcode_t               slot [NUM_BANKS];
    chan_sel_t            sel;
    chan_t                tslot;

    assign bank_en = {bank_en_hi, bank_en_lo};

    seq_test_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .test_en   (test_en),
        .test_wr   (test_wr),
        .test_word (chan_t'(test_word)),
        .hold      (hold),
        .held_word (held_word)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign gate[b] = bank_en[b] & ~hold;
        seq_bank_counter u_cnt (
            .clk        (clk),
            .rst        (rst),
            .line_clr_n (line_clr_n),
            .step_en    (gate[b]),
            .hold       (hold),
            .slot       (slot[b])
        );
    end

    assign tslot = ch_gray_dec(held_word);

    always_comb begin
        sel = '0;
        if (hold) begin
            if (tslot >= TSLOT_FIRST) begin
                sel.valid = 1'b1;
                sel.num   = tslot - TSLOT_FIRST;
            end
        end else begin
            for (int b = NUM_BANKS - 1; b >= 0; b--) begin
                if (gate[b] && slot[b] >= SLOT_FIRST && slot[b] < SLOT_END) begin
                    sel.valid = 1'b1;
                    sel.num   = {1'(b), BANK_W'(slot[b] - SLOT_FIRST)};
                end else if (gate[b]) begin
                    sel = '0;
                end
            end
        end
    end

    assign chan       = 7'(sel.num);
    assign chan_valid = sel.valid;
    assign gate_lo    = gate[0];
    assign gate_hi    = gate[1];

    // R7: with the lower bank stepping, a valid channel is a lower one
    assert_lower_first_R7: assert property (@(posedge clk) disable iff (rst)
        (gate_lo && chan_valid) |-> !chan[6]);

    // R8: hold begins only after a write with test mode enabled
    assert_hold_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> ($past(test_en) && $past(test_wr)));

    // R8: gated enables stay low during hold
    assert_hold_gates_R8: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!gate_lo && !gate_hi));

endmodule

// File: tb/sim_gray_readout_seq.sv
`timescale 1ns/1ps
module sim_gray_readout_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_clr_n = 1'b1;
    logic       bank_en_lo = 1'b0;
    logic       bank_en_hi = 1'b0;
    logic       test_en = 1'b0;
    logic [6:0] test_word = '0;
    logic       test_wr = 1'b0;
    logic [6:0] chan;
    logic       chan_valid;
    logic       gate_lo;
    logic       gate_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_lo = 0, m_hi = 0, m_st = 0, m_code = 0;

    always #2.5 clk = ~clk;

    gray_readout_seq u0 (
        .clk(clk), .rst(rst), .line_clr_n(line_clr_n),
        .bank_en_lo(bank_en_lo), .bank_en_hi(bank_en_hi),
        .test_en(test_en), .test_word(test_word), .test_wr(test_wr),
        .chan(chan), .chan_valid(chan_valid), .gate_lo(gate_lo), .gate_hi(gate_hi)
    );

    // test slot words with expected {valid, channel} (R10)
    localparam logic [14:0] TAB [9] = '{
        {7'h00, 1'b0, 7'd0},
        {7'h01, 1'b0, 7'd0},
        {7'h03, 1'b0, 7'd0},
        {7'h02, 1'b1, 7'd0},
        {7'h06, 1'b1, 7'd1},
        {7'h05, 1'b1, 7'd3},
        {7'h63, 1'b1, 7'd63},
        {7'h62, 1'b1, 7'd64},
        {7'h40, 1'b1, 7'd124}
    };

    function automatic int gdec(input int g);
        int b = 0;
        for (int i = 6; i >= 0; i--) b = b | ((((b >> (i + 1)) ^ (g >> i)) & 1) << i);
        return b;
    endfunction

    task automatic tick(input logic el, input logic eh, input logic cn,
                        input logic te, input logic tw, input logic [6:0] tword,
                        input string tag);
        bit hold_m;
        int s, ev, ec, egl, egh;
        @(negedge clk);
        bank_en_lo = el; bank_en_hi = eh; line_clr_n = cn;
        test_en = te; test_wr = tw; test_word = tword;
        #1;
        hold_m = (m_st == 3);
        ev = 0; ec = 0;
        egl = (el && !hold_m) ? 1 : 0;
        egh = (eh && !hold_m) ? 1 : 0;
        if (hold_m) begin
            s = gdec(m_code);
            if (s >= 3) begin ev = 1; ec = s - 3; end
        end else if (el) begin
            if (m_lo >= 3 && m_lo < 67) begin ev = 1; ec = m_lo - 3; end
        end else if (eh) begin
            if (m_hi >= 3 && m_hi < 67) begin ev = 1; ec = m_hi - 3 + 64; end
        end
        checks++;
        if (chan_valid !== ev[0] || chan !== ec[6:0] || gate_lo !== egl[0] || gate_hi !== egh[0]) begin
            errors++;
            $display("FAIL %s: got valid=%0d chan=%0d gl=%0d gh=%0d, expected valid=%0d chan=%0d gl=%0d gh=%0d",
                     tag, chan_valid, chan, gate_lo, gate_hi, ev, ec, egl, egh);
        end
        if (!cn) begin m_lo = 0; m_hi = 0; end
        else begin
            if (egl && m_lo < 67) m_lo++;
            if (egh && m_hi < 67) m_hi++;
        end
        if (!te) m_st = 0;
        else if (tw) begin
            case (m_st)
                0: m_st = (tword == 7'h01) ? 1 : 0;
                1: m_st = (tword == 7'h02) ? 2 : 0;
                default: begin m_st = 3; m_code = int'(tword); end
            endcase
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bank_en_lo = 0; bank_en_hi = 0; test_en = 0; test_wr = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lo = 0; m_hi = 0; m_st = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        tick(0, 0, 1, 0, 0, 0, "R1 idle after reset");
        tick(1, 0, 1, 0, 0, 0, "R1 first slot after reset");

        // R2 + R5: full lower sweep and beyond
        tick(0, 0, 0, 0, 0, 0, "R6 clear");
        for (int i = 0; i < 70; i++) tick(1, 0, 1, 0, 0, 0, (i < 67) ? "R2 lower sweep" : "R5 saturation");
        // R3 + R5: upper sweep
        tick(0, 0, 0, 0, 0, 0, "R6 clear");
        for (int i = 0; i < 70; i++) tick(0, 1, 1, 0, 0, 0, (i < 67) ? "R3 upper sweep" : "R5 saturation");

        // R4: pause and resume
        tick(0, 0, 0, 0, 0, 0, "R6 clear");
        for (int i = 0; i < 5; i++) tick(1, 0, 1, 0, 0, 0, "R4 before pause");
        for (int i = 0; i < 3; i++) tick(0, 0, 1, 0, 0, 0, "R4 paused");
        for (int i = 0; i < 3; i++) tick(1, 0, 1, 0, 0, 0, "R4 resumed");

        // R6: clear in same cycle as enable
        tick(1, 0, 0, 0, 0, 0, "R6 clear with enable");
        for (int i = 0; i < 5; i++) tick(1, 0, 1, 0, 0, 0, "R6 restart after clear");

        // R7: both enables
        tick(0, 0, 0, 0, 0, 0, "R6 clear");
        for (int i = 0; i < 5; i++) tick(1, 1, 1, 0, 0, 0, "R7 both enabled");
        for (int i = 0; i < 3; i++) tick(0, 1, 1, 0, 0, 0, "R7 upper advanced too");

        // R8: writes with test_en low are ignored
        tick(0, 0, 0, 0, 0, 0, "R6 clear");
        tick(1, 0, 1, 0, 1, 7'h01, "R8 ignored write");
        tick(1, 0, 1, 0, 1, 7'h02, "R8 ignored write");
        tick(1, 0, 1, 0, 1, 7'h02, "R8 ignored write");
        tick(1, 0, 1, 0, 0, 0, "R8 no hold without test_en");

        // R8: unlock while lower bank keeps its enable high
        for (int i = 0; i < 4; i++) tick(1, 0, 1, 0, 0, 0, "R2 advance");
        tick(1, 0, 1, 1, 1, 7'h01, "R8 key one");
        tick(1, 0, 1, 1, 1, 7'h02, "R8 key two");
        tick(1, 0, 1, 1, 1, 7'h06, "R8 slot word");
        for (int i = 0; i < 4; i++) tick(1, 1, 1, 1, 0, 0, "R8 hold frozen");

        // R10: table walk, reloading the held word
        for (int k = 0; k < 9; k++) begin
            tick(0, 0, 1, 1, 1, TAB[k][14:8], "R10 reload");
            tick(0, 0, 1, 1, 0, 0, "R10 decode");
            checks++;
            if (chan_valid !== TAB[k][7] || chan !== TAB[k][6:0]) begin
                errors++;
                $display("FAIL R10 table %0d: got valid=%0d chan=%0d, expected valid=%0d chan=%0d",
                         k, chan_valid, chan, TAB[k][7], TAB[k][6:0]);
            end
        end

        // R11: release and resume from frozen slot
        tick(1, 0, 1, 0, 0, 0, "R11 release edge");
        for (int i = 0; i < 3; i++) tick(1, 0, 1, 0, 0, 0, "R11 resumed");

        // R9: broken sequences
        tick(0, 0, 1, 1, 1, 7'h01, "R9 key one");
        tick(0, 0, 1, 1, 1, 7'h05, "R9 wrong word");
        tick(0, 0, 1, 1, 1, 7'h02, "R9 key two alone");
        tick(0, 0, 1, 1, 1, 7'h02, "R9 not unlocked");
        tick(1, 0, 1, 1, 0, 0, "R9 still counting");
        tick(0, 0, 1, 1, 1, 7'h01, "R9 key one");
        tick(0, 0, 1, 1, 1, 7'h01, "R9 repeated key one");
        tick(0, 0, 1, 1, 1, 7'h02, "R9 key two after break");
        tick(1, 0, 1, 1, 0, 0, "R9 still counting");
        tick(0, 0, 1, 1, 1, 7'h01, "R9 key one");
        tick(0, 0, 1, 1, 1, 7'h02, "R9 key two");
        tick(0, 0, 1, 1, 1, 7'h07, "R9 slot word");
        tick(1, 0, 1, 1, 0, 0, "R9 hold after clean sequence");

        // R1: reset aborts a partial unlock
        tick(0, 0, 1, 0, 0, 0, "R11 release");
        tick(0, 0, 1, 1, 1, 7'h01, "R1 key one");
        tick(0, 0, 1, 1, 1, 7'h02, "R1 key two");
        do_reset();
        tick(0, 0, 1, 1, 1, 7'h02, "R1 word after reset");
        tick(1, 0, 1, 1, 0, 0, "R1 no hold after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule